// File: doc/BRIEF.md
# Block Transfer Engine for Peripheral and Memory

The engine copies a block of words between a selected peripheral data port and system memory, so that the processor only has to set up the job and then deal with its completion. The processor writes the memory start address, the word count and a control word through a small write-only register port. The control word holds the direction, the peripheral select and the transfer mode, and it also starts the job. From then on the engine works alone. It requests the shared system bus with a level request/grant pair, walks the address upward one word at a time and counts the remaining words down to zero. The processor is not interrupted while the engine owns the bus. It simply stalls on its own bus request until the grant returns to it.

Two modes are offered. In word-steal mode the engine gives the bus back after every word. In block mode it keeps the bus from the first grant until the last memory access. Peripheral words move over a valid/ready handshake in each direction. Memory reads return their data one cycle after the read strobe. When the last word has moved, a sticky interrupt is raised. The interrupt is removed only by a write to the status register.

Top module: `dma_engine`

## Requirements
- R1: While reset is asserted and just after it, `busy`, `irq`, `bus_req`, `mem_we`, `mem_re`, `tx_valid` and `rx_ready` are low.
- R2: Register writes are decoded on `cfg_addr`: 0 is control (bit 0 start, bit 1 direction with 1 meaning memory-to-peripheral, bit 2 block mode, bits 11:8 peripheral select), 1 is the memory start address, 2 is the word count and 3 is status. During and after a job, `per_sel` shows the select that was loaded at start.
- R3: `mem_we` or `mem_re` is asserted only in a cycle where both `bus_req` and `bus_gnt` are high. Without a grant the engine waits and makes no access.
- R4: Peripheral-to-memory: word i accepted on the `rx` handshake is written to start address + i, in order. No memory write happens for a word that has not been received, and nothing is written past the block.
- R5: Memory-to-peripheral: the word read at start address + i is offered as the i-th `tx` word. `tx_valid` and `tx_data` stay steady until `tx_ready`, and exactly count words are sent.
- R6: In word-steal mode `bus_req` drops for at least one cycle after each word, so a job of N words raises `bus_req` N times.
- R7: In block mode `bus_req` rises once per job and stays high until the last memory access of the job.
- R8: After the last word, `busy` falls and `irq` rises. `irq` stays high until a status write with bit 0 set. A status write with bit 0 clear leaves it high.
- R9: A start with a word count of zero raises `irq` on the next cycle without any bus request.
- R10: A start written while `busy` is high is ignored. The running job finishes with its original parameters, and no second job follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| busy | output | 1 | Job in progress |
| irq | output | 1 | Sticky completion interrupt |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| mem_addr | output | AW | Memory word address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe, data one cycle later |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| per_sel | output | SELW | Peripheral select of the current job |
| tx_valid | output | 1 | Word offered to peripheral |
| tx_ready | input | 1 | Peripheral accepts word |
| tx_data | output | DW | Word to peripheral |
| rx_valid | input | 1 | Peripheral offers word |
| rx_ready | output | 1 | Engine accepts word |
| rx_data | input | DW | Word from peripheral |

## Verification
Several properties are checked on every cycle. Memory strobes appear only under a granted request. A memory write always has a received word behind it. A stalled `tx` word stays steady. The request drops after each word in word-steal mode and is held in block mode while words remain. The interrupt is sticky, and a zero count completes at once. Other behaviour can only be shown by the bench's scenarios, which compare results with models computed in the bench. These are the order and addresses of the moved data, the absence of writes past the block, the number of bus tenures per job, the exact word count sent, and the rejection of a start during a running job.

// File: rtl/dma_engine_pkg.sv
package dma_engine_pkg;
    localparam int REG_W        = 32;
    localparam int CTRL_START   = 0;
    localparam int CTRL_DIR     = 1;
    localparam int CTRL_BURST   = 2;
    localparam int CTRL_SEL_LSB = 8;

    typedef enum logic [1:0] {
        RG_CTRL   = 2'd0,
        RG_ADDR   = 2'd1,
        RG_COUNT  = 2'd2,
        RG_STATUS = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_GET  = 3'd1,
        S_REQ  = 3'd2,
        S_WR   = 3'd3,
        S_RD   = 3'd4,
        S_RDW  = 3'd5,
        S_PUT  = 3'd6
    } xfer_state_e;
endpackage

// File: rtl/dma_cmd_regs.sv
module dma_cmd_regs
    import dma_engine_pkg::*;
#(
    parameter int AW   = 16,
    parameter int CW   = 16,
    parameter int SELW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             busy_i,
    input  logic             done_i,
    output logic             start_o,
    output logic             dir_o,
    output logic             burst_o,
    output logic [SELW-1:0]  sel_o,
    output logic [AW-1:0]    addr_o,
    output logic [CW-1:0]    cnt_o,
    output logic             irq_o
);
    typedef struct packed {
        logic            dir;
        logic            burst;
        logic [SELW-1:0] sel;
        logic [AW-1:0]   addr;
        logic [CW-1:0]   cnt;
        logic            irq;
    } regs_t;

    regs_t q, d;
    logic  wr_ctrl, wr_addr, wr_cnt, wr_stat, irq_clr;
    logic  wdata_unused;

    assign wdata_unused = ^cfg_wdata;
    assign wr_ctrl = cfg_we && (reg_sel_e'(cfg_addr) == RG_CTRL);
    assign wr_addr = cfg_we && (reg_sel_e'(cfg_addr) == RG_ADDR);
    assign wr_cnt  = cfg_we && (reg_sel_e'(cfg_addr) == RG_COUNT);
    assign wr_stat = cfg_we && (reg_sel_e'(cfg_addr) == RG_STATUS);
    assign irq_clr = wr_stat && cfg_wdata[0];

    always_comb begin
        d = q;
        start_o = 1'b0;
        if (wr_ctrl && !busy_i) begin
            d.dir   = cfg_wdata[CTRL_DIR];
            d.burst = cfg_wdata[CTRL_BURST];
            d.sel   = cfg_wdata[CTRL_SEL_LSB +: SELW];
            start_o = cfg_wdata[CTRL_START];
        end
        if (wr_addr) d.addr = cfg_wdata[AW-1:0];
        if (wr_cnt)  d.cnt  = cfg_wdata[CW-1:0];
        if (done_i)       d.irq = 1'b1;
        else if (irq_clr) d.irq = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dir_o   = d.dir;
    assign burst_o = d.burst;
    assign sel_o   = d.sel;
    assign addr_o  = q.addr;
    assign cnt_o   = q.cnt;
    assign irq_o   = q.irq;

    // R8: the interrupt is cleared only by an explicit status write
    a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (q.irq && !irq_clr) |=> q.irq);

    // R9: an empty job completes on the next cycle with the engine idle
    a_r9_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && q.cnt == '0) |=> (q.irq && !busy_i));
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dma_engine_pkg::*;
#(
    parameter int DW   = 32,
    parameter int AW   = 16,
    parameter int CW   = 16,
    parameter int SELW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            dir_i,
    input  logic            burst_i,
    input  logic [SELW-1:0] sel_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [CW-1:0]   cnt_i,
    output logic            done_o,
    output logic            busy_o,
    output logic            bus_req_o,
    input  logic            bus_gnt_i,
    output logic [AW-1:0]   mem_addr_o,
    output logic            mem_we_o,
    output logic            mem_re_o,
    output logic [DW-1:0]   mem_wdata_o,
    input  logic [DW-1:0]   mem_rdata_i,
    output logic [SELW-1:0] per_sel_o,
    output logic            tx_valid_o,
    input  logic            tx_ready_i,
    output logic [DW-1:0]   tx_data_o,
    input  logic            rx_valid_i,
    output logic            rx_ready_o,
    input  logic [DW-1:0]   rx_data_i
);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);
    localparam logic [AW-1:0] ADDR_ONE = AW'(1);

    typedef struct packed {
        xfer_state_e     st;
        logic            dir;
        logic            burst;
        logic            req;
        logic [SELW-1:0] sel;
        logic [AW-1:0]   addr;
        logic [CW-1:0]   cnt;
        logic [DW-1:0]   buf_w;
        logic            buf_vld;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d      = q;
        done_o = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    if (cnt_i == '0) begin
                        done_o = 1'b1;
                    end else begin
                        d.dir   = dir_i;
                        d.burst = burst_i;
                        d.sel   = sel_i;
                        d.addr  = addr_i;
                        d.cnt   = cnt_i;
                        d.st    = dir_i ? S_REQ : S_GET;
                        d.req   = dir_i;
                    end
                end
            end
            S_GET: begin
                if (rx_valid_i) begin
                    d.buf_w   = rx_data_i;
                    d.buf_vld = 1'b1;
                    if (q.req) begin
                        d.st = S_WR;
                    end else begin
                        d.st  = S_REQ;
                        d.req = 1'b1;
                    end
                end
            end
            S_REQ: begin
                if (bus_gnt_i) d.st = q.dir ? S_RD : S_WR;
            end
            S_WR: begin
                d.addr    = q.addr + ADDR_ONE;
                d.cnt     = q.cnt - CNT_ONE;
                d.buf_vld = 1'b0;
                if (q.cnt == CNT_ONE) begin
                    done_o = 1'b1;
                    d.st   = S_IDLE;
                    d.req  = 1'b0;
                end else begin
                    d.st  = S_GET;
                    d.req = q.burst;
                end
            end
            S_RD: begin
                d.addr = q.addr + ADDR_ONE;
                d.cnt  = q.cnt - CNT_ONE;
                d.st   = S_RDW;
            end
            S_RDW: begin
                d.buf_w   = mem_rdata_i;
                d.buf_vld = 1'b1;
                d.st      = S_PUT;
                d.req     = q.burst && (q.cnt != '0);
            end
            S_PUT: begin
                if (tx_ready_i) begin
                    d.buf_vld = 1'b0;
                    if (q.cnt == '0) begin
                        done_o = 1'b1;
                        d.st   = S_IDLE;
                        d.req  = 1'b0;
                    end else if (q.req) begin
                        d.st = S_RD;
                    end else begin
                        d.st  = S_REQ;
                        d.req = 1'b1;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o      = (q.st != S_IDLE);
    assign bus_req_o   = q.req;
    assign mem_addr_o  = q.addr;
    assign mem_we_o    = (q.st == S_WR);
    assign mem_re_o    = (q.st == S_RD);
    assign mem_wdata_o = q.buf_w;
    assign tx_data_o   = q.buf_w;
    assign tx_valid_o  = (q.st == S_PUT);
    assign rx_ready_o  = (q.st == S_GET);
    assign per_sel_o   = q.sel;

    // R3: memory strobes only under a granted request
    a_r3_access_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o || mem_re_o) |-> (bus_req_o && bus_gnt_i));

    // R4: a memory write always carries a received peripheral word
    a_r4_write_has_word: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> q.buf_vld);

    // R5: a stalled outgoing word holds steady
    a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

    // R6: word-steal mode releases the bus after each word
    a_r6_word_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.burst && (q.st == S_WR || q.st == S_RDW)) |=> !bus_req_o);

    // R7: block mode keeps the bus while more than one word remains
    a_r7_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && q.burst && bus_req_o && bus_gnt_i && q.cnt > CNT_ONE) |=> bus_req_o);
endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_engine_pkg::*;
#(
    parameter int DW   = 32,
    parameter int AW   = 16,
    parameter int CW   = 16,
    parameter int SELW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_addr,
    input  logic [31:0]     cfg_wdata,
    output logic            busy,
    output logic            irq,
    output logic            bus_req,
    input  logic            bus_gnt,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_we,
    output logic            mem_re,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic [SELW-1:0] per_sel,
    output logic            tx_valid,
    input  logic            tx_ready,
    output logic [DW-1:0]   tx_data,
    input  logic            rx_valid,
    output logic            rx_ready,
    input  logic [DW-1:0]   rx_data
);
    logic            start_w, dir_w, burst_w, done_w;
    logic [SELW-1:0] sel_w;
    logic [AW-1:0]   addr_w;
    logic [CW-1:0]   cnt_w;

    dma_cmd_regs #(.AW(AW), .CW(CW), .SELW(SELW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .busy_i(busy), .done_i(done_w),
        .start_o(start_w), .dir_o(dir_w), .burst_o(burst_w), .sel_o(sel_w),
        .addr_o(addr_w), .cnt_o(cnt_w), .irq_o(irq)
    );

    dma_xfer_seq #(.DW(DW), .AW(AW), .CW(CW), .SELW(SELW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_w), .dir_i(dir_w), .burst_i(burst_w), .sel_i(sel_w),
        .addr_i(addr_w), .cnt_i(cnt_w),
        .done_o(done_w), .busy_o(busy),
        .bus_req_o(bus_req), .bus_gnt_i(bus_gnt),
        .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_re_o(mem_re),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .per_sel_o(per_sel),
        .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
        .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .rx_data_i(rx_data)
    );
endmodule

// File: tb/dma_engine_test.sv
module dma_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        busy, irq, bus_req, mem_we, mem_re, tx_valid, rx_ready;
    logic        bus_gnt = 1'b0;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, tx_data, rx_data;
    logic [31:0] mem_rdata = 32'd0;
    logic [3:0]  per_sel;
    logic        tx_ready = 1'b0;
    logic        rx_valid = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] mem [256];
    logic [31:0] cap [32];
    int          ncap = 0;
    int          src_idx = 0;
    logic [7:0]  src_tag = 8'd0;
    int          rises = 0;
    int          viol3 = 0;
    int          viol5 = 0;
    logic        prev_req = 1'b0, prev_txv = 1'b0, prev_txr = 1'b0;
    logic [31:0] prev_txd = 32'd0;

    always #4 clk = ~clk;

    dma_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .busy(busy), .irq(irq), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .per_sel(per_sel),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
    );

    function automatic logic [31:0] src_word(logic [7:0] tag, int i);
        return {tag, 8'h5A, 16'(i)};
    endfunction

    function automatic logic [31:0] mem_pat(logic [7:0] tag, int i);
        return {tag, 8'hC3, 16'(i)};
    endfunction

    function automatic logic [31:0] ctrl_word(bit dir, bit burst, logic [3:0] sel);
        return (32'(sel) << 8) | (32'(burst) << 2) | (32'(dir) << 1) | 32'd1;
    endfunction

    assign rx_data = src_word(src_tag, src_idx);

    // bus arbiter, memory, peripheral source and sink models
    always @(posedge clk) begin
        if (!rst_n)        bus_gnt <= 1'b0;
        else if (!bus_req) bus_gnt <= 1'b0;
        else if (!bus_gnt) bus_gnt <= ($urandom % 3 == 0);
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
        if (rx_valid && rx_ready) src_idx <= src_idx + 1;
        rx_valid <= ($urandom % 3 != 0);
        if (tx_valid && tx_ready) begin
            if (ncap < 32) cap[ncap] <= tx_data;
            ncap <= ncap + 1;
        end
        tx_ready <= ($urandom % 3 != 0);
    end

    // protocol monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if ((mem_we || mem_re) && !(bus_req && bus_gnt)) viol3 <= viol3 + 1;
            if (bus_req && !prev_req) rises <= rises + 1;
            if (prev_txv && !prev_txr && (!tx_valid || tx_data != prev_txd)) viol5 <= viol5 + 1;
        end
        prev_req <= bus_req;
        prev_txv <= tx_valid;
        prev_txr <= tx_ready;
        prev_txd <= tx_data;
    end

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_irq();
        int t = 0;
        while (!irq && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk(irq, "R8 irq after last word", 32'(irq), 32'd1);
    endtask

    task automatic setup(bit dir, int addr, int cnt, logic [7:0] tag);
        @(negedge clk);
        rises = 0; ncap = 0; src_idx = 0; src_tag = tag;
        for (int i = 0; i < cnt; i++) begin
            if (dir) mem[(addr + i) & 255] = mem_pat(tag, i);
            else     mem[(addr + i) & 255] = 32'hFFFF_0000;
        end
        mem[(addr + cnt) & 255] = {8'hEE, tag, 16'h0};
    endtask

    task automatic finish_check(bit dir, bit burst, logic [3:0] sel, int addr, int cnt, logic [7:0] tag);
        wait_irq();
        repeat (3) @(negedge clk);
        chk(!busy, "R8 busy low after job", 32'(busy), 32'd0);
        chk(per_sel == sel, "R2 peripheral select", 32'(per_sel), 32'(sel));
        chk(viol3 == 0, "R3 access without grant", 32'(viol3), 32'd0);
        chk(rises == (burst ? 1 : cnt), burst ? "R7 block tenures" : "R6 word tenures",
            32'(rises), 32'(burst ? 1 : cnt));
        if (dir) begin
            chk(ncap == cnt, "R5 word count sent", 32'(ncap), 32'(cnt));
            chk(viol5 == 0, "R5 tx held stable", 32'(viol5), 32'd0);
            for (int i = 0; i < cnt && i < 32; i++)
                chk(cap[i] == mem_pat(tag, i), "R5 tx word order", cap[i], mem_pat(tag, i));
        end else begin
            for (int i = 0; i < cnt; i++)
                chk(mem[(addr + i) & 255] == src_word(tag, i), "R4 memory word",
                    mem[(addr + i) & 255], src_word(tag, i));
            chk(mem[(addr + cnt) & 255] == {8'hEE, tag, 16'h0}, "R4 no write past block",
                mem[(addr + cnt) & 255], {8'hEE, tag, 16'h0});
        end
        chk(irq, "R8 irq held", 32'(irq), 32'd1);
        wr(2'd3, 32'd0);
        chk(irq, "R8 irq kept on status write of 0", 32'(irq), 32'd1);
        wr(2'd3, 32'd1);
        chk(!irq, "R8 irq cleared", 32'(irq), 32'd0);
    endtask

    task automatic run(bit dir, bit burst, logic [3:0] sel, int addr, int cnt, logic [7:0] tag);
        setup(dir, addr, cnt, tag);
        wr(2'd1, 32'(addr));
        wr(2'd2, 32'(cnt));
        wr(2'd0, ctrl_word(dir, burst, sel));
        finish_check(dir, burst, sel, addr, cnt, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h0D3A_5EED));
        repeat (4) @(negedge clk);
        chk(!busy && !irq && !bus_req, "R1 reset state", {29'd0, busy, irq, bus_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_we && !mem_re && !tx_valid && !rx_ready, "R1 idle strobes",
            {28'd0, mem_we, mem_re, tx_valid, rx_ready}, 32'd0);

        // directed corner cases
        run(1'b0, 1'b0, 4'h3, 8'h10, 3, 8'h01);
        run(1'b0, 1'b1, 4'h7, 8'h20, 4, 8'h02);
        run(1'b1, 1'b0, 4'hA, 8'h30, 3, 8'h03);
        run(1'b1, 1'b1, 4'h5, 8'h40, 5, 8'h04);
        run(1'b1, 1'b1, 4'h1, 8'h50, 1, 8'h05);

        // R9: empty job
        @(negedge clk); rises = 0;
        wr(2'd2, 32'd0);
        wr(2'd0, ctrl_word(1'b1, 1'b0, 4'h2));
        chk(irq, "R9 zero count irq", 32'(irq), 32'd1);
        chk(!busy, "R9 zero count not busy", 32'(busy), 32'd0);
        repeat (3) @(negedge clk);
        chk(rises == 0, "R9 no bus request", 32'(rises), 32'd0);
        wr(2'd3, 32'd1);

        // R10: start during a running job
        setup(1'b0, 8'h60, 6, 8'h06);
        mem[8'h90] = 32'h1234_5678;
        wr(2'd1, 32'h60);
        wr(2'd2, 32'd6);
        wr(2'd0, ctrl_word(1'b0, 1'b0, 4'h9));
        wr(2'd1, 32'h90);
        wr(2'd0, ctrl_word(1'b1, 1'b1, 4'h4));
        finish_check(1'b0, 1'b0, 4'h9, 8'h60, 6, 8'h06);
        repeat (30) @(negedge clk);
        chk(!busy && !irq, "R10 no second job", {30'd0, busy, irq}, 32'd0);
        chk(ncap == 0, "R10 no words sent", 32'(ncap), 32'd0);
        chk(mem[8'h90] == 32'h1234_5678, "R10 other region untouched", mem[8'h90], 32'h1234_5678);

        // constrained random jobs
        for (int k = 0; k < 12; k++) begin
            bit dir_r   = 1'($urandom % 2);
            bit burst_r = 1'($urandom % 2);
            int cnt_r   = 1 + int'($urandom % 8);
            int addr_r  = int'($urandom % 240);
            run(dir_r, burst_r, 4'($urandom), addr_r, cnt_r, 8'(8'h10 + k));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule